// File: doc/BRIEF.md
# Priority-Masked Interrupt Entry Controller

This block sits beside a processor pipeline and decides when external interrupt requests redirect execution to a handler. Each request line has a fixed urgency given by its index, with the highest index most urgent. A request pulse latches a pending bit that stays set until software clears it. When the global enable is set and the most urgent pending line ranks strictly above the current priority level held in a software-visible register, the block issues a one-cycle trap. In that same clock edge it captures the interrupted PC, disables further interrupts and enters supervisor mode.

A single shadow context keeps the mode and enable that were active before entry. A return-from-exception input restores them and pulses a return strobe, and the processor resumes at the saved PC. To nest, a handler first saves the shadow state itself. It then raises the level to its own urgency and sets the enable again. A more urgent line can then preempt the handler, while requests at or below the raised level stay blocked.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, trap_o, ret_o, int_en_o and supervisor_o are 0, and the level and pending registers both read 0.
- R2: A one-cycle high on irq_i[i] sets pending bit i, which reads back at register offset 2, bit i. The bit stays set until software writes a 1 to bit i at offset 2. Writing a 0 to a bit leaves it unchanged.
- R3: When int_en_o is 1 and the highest set pending index is strictly greater than the level, trap_o is high for exactly one cycle. It goes high on the clock edge after the pending bit first reads as set.
- R4: On the edge that raises trap_o, epc_o takes the value of cur_pc_i at that edge, int_en_o goes to 0 and supervisor_o goes to 1.
- R5: vector_o equals VEC_BASE plus 16 times the highest set pending index at entry. The default VEC_BASE is 0x100.
- R6: A pending line whose index is less than or equal to the level is never accepted. Lowering the level below that index by a register write leads to a trap on the following edge.
- R7: While int_en_o is 0, no trap is taken, whatever is pending.
- R8: A one-cycle high on rte_i pulses ret_o on the next edge. On that same edge, supervisor_o and int_en_o return to the values they held just before the most recent entry.
- R9: A handler that raises the level and sets the enable can be preempted by a more urgent line. After the nested entry, a return restores supervisor mode with the enable set.
- R10: Register offset 0 holds the level in bits [2:0] and reads back what was written. At offset 1, bit 0 is the global enable, which can be written and read back. Bit 1 at offset 1 reads supervisor mode and ignores writes.
- R11: If rte_i and an acceptable request coincide on an edge, the return wins: ret_o pulses and trap_o stays 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_SRC | Request pulses, index = urgency |
| cur_pc_i | input | PC_W | PC of the instruction at the interrupt point |
| rte_i | input | 1 | Return-from-exception strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| trap_o | output | 1 | One-cycle trap request |
| vector_o | output | PC_W | Handler address for the accepted line |
| epc_o | output | PC_W | Saved interrupted PC |
| ret_o | output | 1 | One-cycle return strobe (resume at epc_o) |
| supervisor_o | output | 1 | Current mode, 1 = supervisor |
| int_en_o | output | 1 | Global interrupt enable |

## Verification
The bench targets several corner cases of the acceptance rule. A request at exactly the current level must stay blocked, because a design that compares with greater-or-equal would re-enter the running handler. Two lines raised together must yield the vector of the more urgent one, so an inverted encoder shows up as the wrong handler address. The nested scenario checks that a raised level still lets a disk-class line through and that the return restores supervisor mode rather than forcing user mode. A coincident return and request checks that the two updates do not both land on the same edge, which would corrupt the mode and enable.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic {
      MODE_USER  = 1'b0,
      MODE_SUPER = 1'b1
   } priv_e;

   typedef struct packed {
      priv_e mode;
      logic  en;
   } ctx_t;

   localparam int OFS_LEVEL   = 0;
   localparam int OFS_ENABLE  = 1;
   localparam int OFS_PENDING = 2;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[g] <= 1'b0;
         else if (set_i[g])
            pend_o[g] <= 1'b1;
         else if (clr_i[g])
            pend_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          valid_o,
   output logic [LW-1:0] idx_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = LW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_csr.sv
module irq_csr
   import irq_entry_pkg::*;
#(
   parameter int N      = 8,
   parameter int LW     = 3,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [N-1:0]      pend_i,
   input  logic              en_i,
   input  priv_e             mode_i,
   output logic [LW-1:0]     lvl_o,
   output logic              en_wr_o,
   output logic              en_wdata_o,
   output logic [N-1:0]      pend_clr_o
);
   localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(OFS_LEVEL);
   localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(OFS_PENDING);

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_o <= '0;
      else if (we_i && addr_i == A_LVL)
         lvl_o <= wdata_i[LW-1:0];
   end

   assign en_wr_o    = we_i && (addr_i == A_ENA);
   assign en_wdata_o = wdata_i[0];
   assign pend_clr_o = (we_i && addr_i == A_PND) ? wdata_i[N-1:0] : '0;

   always_comb begin
      unique case (addr_i)
         A_LVL:   rdata_o = DATA_W'(lvl_o);
         A_ENA:   rdata_o = DATA_W'({mode_i == MODE_SUPER, en_i});
         A_PND:   rdata_o = DATA_W'(pend_i);
         default: rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
#(
   parameter int              NUM_SRC   = 8,
   parameter int              PC_W      = 32,
   parameter int              DATA_W    = 32,
   parameter int              ADDR_W    = 4,
   parameter int              VEC_SHIFT = 4,
   parameter logic [PC_W-1:0] VEC_BASE  = PC_W'(32'h100)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic [PC_W-1:0]    cur_pc_i,
   input  logic               rte_i,
   input  logic               reg_we_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               trap_o,
   output logic [PC_W-1:0]    vector_o,
   output logic [PC_W-1:0]    epc_o,
   output logic               ret_o,
   output logic               supervisor_o,
   output logic               int_en_o
);
   localparam int LVL_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC != (1 << LVL_W)) begin : g_bad_src
      $error("NUM_SRC must be a power of two of at least 2");
   end
   if (DATA_W < NUM_SRC || DATA_W < 2) begin : g_bad_data
      $error("DATA_W too narrow for the pending register");
   end
   if (PC_W <= LVL_W + VEC_SHIFT) begin : g_bad_pc
      $error("PC_W too narrow for the vector table");
   end

   logic [NUM_SRC-1:0] pend, pend_clr;
   logic [LVL_W-1:0]   lvl_q, pick_idx;
   logic               pick_valid, take, en_wr, en_wdata;
   logic               en_q;
   priv_e              mode_q;
   ctx_t               shadow_q;

   irq_pend_bank #(.N(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_i),
      .clr_i  (pend_clr),
      .pend_o (pend)
   );

   irq_prio_pick #(.N(NUM_SRC), .LW(LVL_W)) u_pick (
      .req_i   (pend),
      .valid_o (pick_valid),
      .idx_o   (pick_idx)
   );

   irq_csr #(.N(NUM_SRC), .LW(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (reg_rdata_o),
      .pend_i     (pend),
      .en_i       (en_q),
      .mode_i     (mode_q),
      .lvl_o      (lvl_q),
      .en_wr_o    (en_wr),
      .en_wdata_o (en_wdata),
      .pend_clr_o (pend_clr)
   );

   assign take = en_q && pick_valid && (pick_idx > lvl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o   <= 1'b0;
         ret_o    <= 1'b0;
         vector_o <= VEC_BASE;
         epc_o    <= '0;
         en_q     <= 1'b0;
         mode_q   <= MODE_USER;
         shadow_q <= '{mode: MODE_USER, en: 1'b0};
      end else begin
         trap_o <= 1'b0;
         ret_o  <= 1'b0;
         if (rte_i) begin
            ret_o  <= 1'b1;
            en_q   <= shadow_q.en;
            mode_q <= shadow_q.mode;
         end else if (take) begin
            trap_o   <= 1'b1;
            vector_o <= VEC_BASE + (PC_W'(pick_idx) << VEC_SHIFT);
            epc_o    <= cur_pc_i;
            shadow_q <= '{mode: mode_q, en: en_q};
            en_q     <= 1'b0;
            mode_q   <= MODE_SUPER;
         end else if (en_wr) begin
            en_q <= en_wdata;
         end
      end
   end

   assign supervisor_o = (mode_q == MODE_SUPER);
   assign int_en_o     = en_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int              NUM_SRC   = 8,
   parameter int              PC_W      = 32,
   parameter int              VEC_SHIFT = 4,
   parameter logic [PC_W-1:0] VEC_BASE  = PC_W'(32'h100)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       trap_o,
   input logic                       ret_o,
   input logic                       rte_i,
   input logic                       int_en_o,
   input logic                       supervisor_o,
   input logic [PC_W-1:0]            epc_o,
   input logic [PC_W-1:0]            vector_o,
   input logic [PC_W-1:0]            cur_pc_i,
   input logic [$clog2(NUM_SRC)-1:0] lvl_q
);
   logic [PC_W-1:0] vec_idx;
   assign vec_idx = (vector_o - VEC_BASE) >> VEC_SHIFT;

   assert_trap_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> !trap_o);

   assert_entry_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (!int_en_o && supervisor_o));

   assert_epc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_o) |-> (epc_o == $past(cur_pc_i)));

   assert_above_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_o) |-> (vec_idx > PC_W'($past(lvl_q))));

   assert_no_trap_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en_o |=> !trap_o);

   assert_ret_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rte_i |=> ret_o);

   assert_ret_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rte_i |=> !trap_o);
endmodule

bind irq_entry_ctrl irq_entry_chk #(
   .NUM_SRC   (NUM_SRC),
   .PC_W      (PC_W),
   .VEC_SHIFT (VEC_SHIFT),
   .VEC_BASE  (VEC_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trap_o       (trap_o),
   .ret_o        (ret_o),
   .rte_i        (rte_i),
   .int_en_o     (int_en_o),
   .supervisor_o (supervisor_o),
   .epc_o        (epc_o),
   .vector_o     (vector_o),
   .cur_pc_i     (cur_pc_i),
   .lvl_q        (lvl_q)
);

// File: tb/tb_irq_entry_ctrl.sv
`timescale 1ns/1ps
module tb_irq_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_i = '0;
   logic [31:0] cur_pc_i = '0;
   logic        rte_i = 1'b0;
   logic        reg_we_i = 1'b0;
   logic [3:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o, vector_o, epc_o;
   logic        trap_o, ret_o, supervisor_o, int_en_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_entry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cur_pc_i(cur_pc_i),
      .rte_i(rte_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .trap_o(trap_o), .vector_o(vector_o), .epc_o(epc_o),
      .ret_o(ret_o), .supervisor_o(supervisor_o), .int_en_o(int_en_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_we_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr_i = a;
      #0.5;
      d = reg_rdata_o;
   endtask

   task automatic pulse_irq(input logic [7:0] v);
      @(negedge clk); irq_i = v;
      @(negedge clk); irq_i = '0;
   endtask

   task automatic do_rte();
      @(negedge clk); rte_i = 1'b1;
      @(negedge clk); rte_i = 1'b0;
   endtask

   task automatic expect_entry(input string tag, input logic [31:0] vec, input logic [31:0] pc);
      @(negedge clk);
      chk({tag, " trap"}, 32'(trap_o), 1);
      chk({tag, " vector R5"}, vector_o, vec);
      chk({tag, " epc R4"}, epc_o, pc);
      chk({tag, " super R4"}, 32'(supervisor_o), 1);
      chk({tag, " en R4"}, 32'(int_en_o), 0);
      @(negedge clk);
      chk({tag, " pulse R3"}, 32'(trap_o), 0);
   endtask

   task automatic expect_quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tag, 32'(trap_o), 0);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 trap", 32'(trap_o), 0);
      chk("R1 ret", 32'(ret_o), 0);
      chk("R1 en", 32'(int_en_o), 0);
      chk("R1 super", 32'(supervisor_o), 0);
      rd(4'd0, d); chk("R1 level", d, 0);
      rd(4'd2, d); chk("R1 pending", d, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(4'd0, 32'h5); rd(4'd0, d); chk("R10 level", d, 5);
      wr(4'd1, 32'h3); rd(4'd1, d); chk("R10 enable ro mode", d, 1);
      chk("R10 super ignored", 32'(supervisor_o), 0);
      wr(4'd1, 32'h0); rd(4'd1, d); chk("R10 enable clr", d, 0);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_pending();
      logic [31:0] d;
      pulse_irq(8'h08);
      expect_quiet("R7 disabled no trap", 3);
      rd(4'd2, d); chk("R2 sticky", d, 32'h08);
      wr(4'd2, 32'h00); rd(4'd2, d); chk("R2 zero write", d, 32'h08);
      wr(4'd2, 32'h08); rd(4'd2, d); chk("R2 cleared", d, 0);
   endtask

   task automatic t_entry_rte();
      wr(4'd1, 32'h1);
      cur_pc_i = 32'h1234;
      pulse_irq(8'h44);
      expect_entry("R3 highest of two", 32'h160, 32'h1234);
      wr(4'd2, 32'hFF);
      do_rte();
      chk("R8 ret", 32'(ret_o), 1);
      chk("R8 user", 32'(supervisor_o), 0);
      chk("R8 en", 32'(int_en_o), 1);
   endtask

   task automatic t_level();
      wr(4'd0, 32'h4);
      pulse_irq(8'h10);
      expect_quiet("R6 same level blocked", 4);
      cur_pc_i = 32'h2000;
      wr(4'd0, 32'h3);
      expect_entry("R6 lowered level", 32'h140, 32'h2000);
      wr(4'd2, 32'hFF);
      wr(4'd0, 32'h0);
      do_rte();
   endtask

   task automatic t_nest();
      cur_pc_i = 32'h3000;
      pulse_irq(8'h04);
      expect_entry("R9 network entry", 32'h120, 32'h3000);
      wr(4'd0, 32'h2);
      wr(4'd2, 32'h04);
      wr(4'd1, 32'h1);
      pulse_irq(8'h02);
      expect_quiet("R9 lower blocked", 3);
      cur_pc_i = 32'h3400;
      pulse_irq(8'h40);
      expect_entry("R9 disk preempts", 32'h160, 32'h3400);
      wr(4'd2, 32'hFF);
      do_rte();
      chk("R9 ret", 32'(ret_o), 1);
      chk("R9 back to super", 32'(supervisor_o), 1);
      chk("R9 en restored", 32'(int_en_o), 1);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_collide();
      @(negedge clk); irq_i = 8'h08;
      @(negedge clk); irq_i = '0; rte_i = 1'b1;
      @(negedge clk); rte_i = 1'b0;
      chk("R11 ret wins", 32'(ret_o), 1);
      chk("R11 no trap", 32'(trap_o), 0);
      @(negedge clk);
      chk("R11 trap after", 32'(trap_o), 1);
      chk("R11 vector", vector_o, 32'h130);
   endtask

   initial begin
      #20000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_pending();
      t_entry_rte();
      t_level();
      t_nest();
      t_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule